// File: doc/BRIEF.md
# Linked-List Source DMA Channel

This block is a single DMA channel that moves 128-bit quadwords from memory into a peripheral FIFO by walking a chain of 128-bit descriptors ("tags") held in memory. Software programs the tag address, optionally a memory address and a starting count, and then sets the start bit in the control register. The channel alternates between two kinds of step: a data step reads one quadword and pushes it into the FIFO, and a tag step reads the next descriptor and reloads the count and the memory address from it.

Each step waits for the peripheral's request line, so the transfer can pause at any quadword boundary and resume later. A descriptor can mark itself as the last of the chain through its ID field. Its interrupt flag also ends the chain, but only when tag interrupts are enabled in the control register. Once the last descriptor's data has gone out, the channel pulses its interrupt output and clears its busy bit.

Top module: `dma_chain_src`

## Requirements
- R1: While reset is held, and after reset, `mem_req`, `fifo_we` and `irq` are low and `ctrl_o` reads 0.
- R2: Control bit 8 is the start/busy bit. While it is clear, no memory request is made, whatever `dreq` does. The other control bits keep the value written, and hardware changes only bit 8.
- R3: A tag step reads the quadword at the tag address with `mem_spr` driven by tag address bit 31. Tag layout: bits 27:0 count, 30:28 ID, 31 interrupt flag, 62:32 data address, 63 memory select. The step loads the count and the data address. It advances the tag address by 16 only when the tag does not end the chain.
- R4: While the count is nonzero, each data step reads the quadword at the memory address and writes it unchanged to the FIFO port. It then adds 16 to the address and decrements the count. At most one read is outstanding at a time.
- R5: A tag with ID 7 ends the chain. The tag's interrupt flag ends the chain only when control bit 7 is set, and is ignored otherwise.
- R6: When the count is zero and the chain has ended, the next step raises `irq` for exactly one cycle, clears control bit 8 and leaves the count at zero.
- R7: No new step begins while `dreq` is low. A read already issued completes, and the transfer resumes in order once `dreq` returns high.
- R8: Writing control bit 8 as 1 lets the first step start even if `dreq` is low. Later steps need `dreq`.
- R9: An access goes to scratchpad (`mem_spr`=1) when the tag's memory-select bit or address bit 31 is set, and presents address bits 13:4 with all other bits zero. Otherwise it presents the address with bits 3:0 cleared.
- R10: A nonzero count written before the start bit is transferred from the written memory address before the first tag is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 memory address, 2 tag address, 3 count |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req | output | 1 | One-cycle memory read request |
| mem_spr | output | 1 | Request targets scratchpad |
| mem_addr | output | 32 | Quadword-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read data |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 128 | FIFO write data |
| dreq | input | 1 | Peripheral ready for more data |
| irq | output | 1 | One-cycle chain-complete interrupt |
| ctrl_o | output | 32 | Current control register value |

## Verification
The assertions take for granted that memory returns exactly one `mem_rvalid` for each request and none without one. They also assume the count register is not rewritten while a data read is in flight. The bench memory model answers every request on the following cycle with data derived from the address, or with a descriptor from a small table. All configuration writes are made while the channel is idle. Within those limits, the bench drops `dreq` in the middle of a chain and starts the channel with `dreq` low, which exercises the pause and forced-first-step properties.

// File: rtl/dma_chain_pkg.sv
// Package: shared constants, descriptor layout and state types for the
// linked-list source DMA channel. Assumes 128-bit quadwords and 32-bit addresses.
package dma_chain_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ADDR_W   = 32;
    localparam int QW_W     = 128;
    localparam int QWC_W    = 28;
    localparam int QW_BYTES = 16;

    localparam int CTRL_START = 8;
    localparam int CTRL_TIE   = 7;

    localparam logic [2:0] TAG_ID_LAST = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } step_st_t;

    typedef enum logic [1:0] {
        CFG_CTRL = 2'd0,
        CFG_MADR = 2'd1,
        CFG_TADR = 2'd2,
        CFG_QWC  = 2'd3
    } cfg_sel_t;

    // Lower 64 bits of a descriptor; the upper 64 bits carry no control meaning.
    typedef struct packed {
        logic              mem_sel;
        logic [30:0]       addr;
        logic              irq_flag;
        logic [2:0]        id;
        logic [QWC_W-1:0]  qwc;
    } tag_lo_t;
endpackage

// File: rtl/dma_tag_decode.sv
// Module: dma_tag_decode
// Unpacks the control half of a fetched descriptor and decides whether the
// descriptor closes the chain. Purely combinational; assumes the caller only
// uses the outputs in the cycle the descriptor arrives.
module dma_tag_decode
    import dma_chain_pkg::*;
(
    input  logic [63:0]        tag_lo,
    input  logic               tie_en,
    output logic [QWC_W-1:0]   qwc,
    output logic [ADDR_W-1:0]  data_addr,
    output logic               mem_sel,
    output logic               ends_chain
);
    timeunit 1ns;
    timeprecision 1ps;

    tag_lo_t fields;

    // Field unpack and chain-end decision.
    always_comb begin
        fields     = tag_lo_t'(tag_lo);
        qwc        = fields.qwc;
        data_addr  = {1'b0, fields.addr};
        mem_sel    = fields.mem_sel;
        ends_chain = (fields.id == TAG_ID_LAST) || (tie_en && fields.irq_flag);
    end
endmodule

// File: rtl/dma_mem_route.sv
// Module: dma_mem_route
// Chooses between scratchpad and main memory for one access and forms the
// presented address. Takes the address without its byte offset, so the
// result is always quadword aligned.
module dma_mem_route
    import dma_chain_pkg::*;
#(
    parameter int SPR_BYTES = 16384
) (
    input  logic [ADDR_W-1:4]  qaddr,
    input  logic               force_spr,
    output logic               spr,
    output logic [ADDR_W-1:0]  addr_out
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SPR_MSB = $clog2(SPR_BYTES) - 1;
    localparam int PAD_W   = ADDR_W - 1 - SPR_MSB;

    // Target selection and address shaping.
    always_comb begin
        spr = force_spr || qaddr[ADDR_W-1];
        if (spr) begin
            addr_out = {{PAD_W{1'b0}}, qaddr[SPR_MSB:4], 4'b0000};
        end else begin
            addr_out = {qaddr, 4'b0000};
        end
    end
endmodule

// File: rtl/dma_step_gate.sv
// Module: dma_step_gate
// Decides whether a step may start this cycle. A start write arms a one-shot
// permission that stands in for the request line until the first step launches.
module dma_step_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic dreq,
    input  logic launch,
    output logic go
);
    timeunit 1ns;
    timeprecision 1ps;

    logic kick_q;

    // One-shot permission armed by start, consumed by the first launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick_q <= 1'b0;
        end else if (start_wr) begin
            kick_q <= 1'b1;
        end else if (launch) begin
            kick_q <= 1'b0;
        end
    end

    // Step permission.
    always_comb go = dreq || kick_q;

    p_launch_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (dreq || kick_q));
endmodule

// File: rtl/dma_chain_src.sv
// Module: dma_chain_src
// Linked-list source DMA channel. Alternates descriptor fetches and quadword
// moves from memory to a FIFO port, one step per request-line grant.
// Assumes memory answers every request with exactly one mem_rvalid and that
// configuration writes are made while no read is in flight.
module dma_chain_src
    import dma_chain_pkg::*;
#(
    parameter int SPR_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_req,
    output logic              mem_spr,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [QW_W-1:0]   mem_rdata,
    output logic              fifo_we,
    output logic [QW_W-1:0]   fifo_wdata,
    input  logic              dreq,
    output logic              irq,
    output logic [31:0]       ctrl_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [ADDR_W-1:0] QW_STEP = ADDR_W'(QW_BYTES);

    step_st_t          st_q;
    logic [31:0]       ctrl_q;
    logic [ADDR_W-1:0] madr_q;
    logic [ADDR_W-1:0] tadr_q;
    logic [QWC_W-1:0]  qwc_q;
    logic              end_q;
    logic              msel_q;
    logic              irq_q;

    logic              start_wr;
    logic              go;
    logic              need_data;
    logic              finish;
    logic              step_ok;
    logic [ADDR_W-1:0] step_addr;
    logic              step_force;

    logic [QWC_W-1:0]  dec_qwc;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_msel;
    logic              dec_ends;

    // Start detection from the configuration port.
    always_comb start_wr = cfg_we && (cfg_sel_t'(cfg_sel) == CFG_CTRL)
                           && cfg_wdata[CTRL_START];

    // Step decision: data first, then finish or next descriptor.
    always_comb begin
        need_data  = (qwc_q != '0);
        finish     = !need_data && end_q;
        step_ok    = (st_q == ST_IDLE) && ctrl_q[CTRL_START] && go;
        mem_req    = step_ok && !finish;
        step_addr  = need_data ? madr_q : tadr_q;
        step_force = need_data && msel_q;
    end

    // FIFO write path: read data passes straight through.
    always_comb begin
        fifo_we    = (st_q == ST_DATA) && mem_rvalid;
        fifo_wdata = mem_rdata;
        irq        = irq_q;
        ctrl_o     = ctrl_q;
    end

    dma_step_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .dreq     (dreq),
        .launch   (mem_req),
        .go       (go)
    );

    dma_mem_route #(
        .SPR_BYTES (SPR_BYTES)
    ) u_route (
        .qaddr     (step_addr[ADDR_W-1:4]),
        .force_spr (step_force),
        .spr       (mem_spr),
        .addr_out  (mem_addr)
    );

    dma_tag_decode u_dec (
        .tag_lo     (mem_rdata[63:0]),
        .tie_en     (ctrl_q[CTRL_TIE]),
        .qwc        (dec_qwc),
        .data_addr  (dec_addr),
        .mem_sel    (dec_msel),
        .ends_chain (dec_ends)
    );

    // Channel registers and step sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ctrl_q <= '0;
            madr_q <= '0;
            tadr_q <= '0;
            qwc_q  <= '0;
            end_q  <= 1'b0;
            msel_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (cfg_we) begin
                case (cfg_sel_t'(cfg_sel))
                    CFG_CTRL: begin
                        ctrl_q <= cfg_wdata;
                        if (cfg_wdata[CTRL_START]) end_q <= 1'b0;
                    end
                    CFG_MADR: begin
                        madr_q <= cfg_wdata;
                        msel_q <= 1'b0;
                    end
                    CFG_TADR: tadr_q <= cfg_wdata;
                    CFG_QWC:  qwc_q  <= cfg_wdata[QWC_W-1:0];
                    default:  ;
                endcase
            end
            case (st_q)
                ST_IDLE: begin
                    if (step_ok) begin
                        if (finish) begin
                            irq_q              <= 1'b1;
                            ctrl_q[CTRL_START] <= 1'b0;
                            qwc_q              <= '0;
                        end else if (need_data) begin
                            st_q <= ST_DATA;
                        end else begin
                            st_q <= ST_TAG;
                        end
                    end
                end
                ST_TAG: begin
                    if (mem_rvalid) begin
                        qwc_q  <= dec_qwc;
                        madr_q <= dec_addr;
                        msel_q <= dec_msel;
                        end_q  <= dec_ends;
                        if (!dec_ends) tadr_q <= tadr_q + QW_STEP;
                        st_q   <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (mem_rvalid) begin
                        madr_q <= madr_q + QW_STEP;
                        qwc_q  <= qwc_q - QWC_W'(1);
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    p_irq_clears_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !ctrl_q[CTRL_START]);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_we |=> (qwc_q == $past(qwc_q) - QWC_W'(1)));

    p_req_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ctrl_q[CTRL_START]);
endmodule

// File: tb/dma_chain_src_bench.sv
module dma_chain_src_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] TAG_BASE = 32'h0000_8000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we;
    logic [1:0]   cfg_sel;
    logic [31:0]  cfg_wdata;
    logic         mem_req;
    logic         mem_spr;
    logic [31:0]  mem_addr;
    logic         mem_rvalid = 1'b0;
    logic [127:0] mem_rdata = '0;
    logic         fifo_we;
    logic [127:0] fifo_wdata;
    logic         dreq;
    logic         irq;
    logic [31:0]  ctrl_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_wr = 0;
    int n_req = 0;
    int n_irq = 0;
    bit done = 1'b0;
    logic [127:0] got   [16];
    logic [31:0]  req_a [16];
    logic         req_s [16];
    logic [127:0] tag_tbl [8];
    logic [127:0] exp_d [5];

    always #5 clk = ~clk;

    dma_chain_src u_dma_chain_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .mem_req    (mem_req),
        .mem_spr    (mem_spr),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .fifo_we    (fifo_we),
        .fifo_wdata (fifo_wdata),
        .dreq       (dreq),
        .irq        (irq),
        .ctrl_o     (ctrl_o)
    );

    function automatic logic [127:0] pat(input logic spr, input logic [31:0] a);
        return {a ^ 32'hC3C3_0000, ~a, a + 32'h0000_1111, spr ? 32'h5C5C_5C5C : 32'h0};
    endfunction

    function automatic logic [127:0] mk_tag(input logic [27:0] q, input logic [2:0] id,
                                            input logic irqf, input logic [30:0] a,
                                            input logic m);
        return {64'hFEED_F00D_0BAD_C0DE, m, a, irqf, id, q};
    endfunction

    // Memory model: answers each request on the next cycle.
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        if (!mem_spr && mem_addr >= TAG_BASE && mem_addr < TAG_BASE + 32'd128)
            mem_rdata <= tag_tbl[3'((mem_addr - TAG_BASE) >> 4)];
        else
            mem_rdata <= pat(mem_spr, mem_addr);
    end

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_we) begin
                if (n_wr < 16) got[n_wr] = fifo_wdata;
                n_wr++;
            end
            if (mem_req) begin
                if (n_req < 16) begin
                    req_a[n_req] = mem_addr;
                    req_s[n_req] = mem_spr;
                end
                n_req++;
            end
            if (irq) n_irq++;
        end
    end

    task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic mon_clr();
        n_wr = 0; n_req = 0; n_irq = 0;
    endtask

    task automatic idle_cycles(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); #1;
            if (!ctrl_o[8]) break;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int r0;
        cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0; dreq = 1'b0;
        for (int i = 0; i < 8; i++) tag_tbl[i] = '0;
        tag_tbl[0] = mk_tag(28'd3, 3'd3, 1'b1, 31'h100, 1'b0);
        tag_tbl[1] = mk_tag(28'd2, 3'd7, 1'b0, 31'h6040, 1'b1);
        exp_d[0] = pat(1'b0, 32'h100);
        exp_d[1] = pat(1'b0, 32'h110);
        exp_d[2] = pat(1'b0, 32'h120);
        exp_d[3] = pat(1'b1, 32'h2040);
        exp_d[4] = pat(1'b1, 32'h2050);

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ctrl", 128'(ctrl_o), 128'h0);
        chk("R1 mem_req", 128'(mem_req), 128'h0);
        chk("R1 fifo_we", 128'(fifo_we), 128'h0);
        chk("R1 irq", 128'(irq), 128'h0);
        rst_n = 1'b1;

        // R2: start bit clear, no activity
        dreq = 1'b1;
        mon_clr();
        cfg_wr(2'd0, 32'h004);
        idle_cycles(20);
        chk("R2 no req", 128'(n_req), 128'd0);
        chk("R2 no write", 128'(n_wr), 128'd0);
        chk("R2 ctrl kept", 128'(ctrl_o), 128'h004);

        // Two-descriptor chain, tag interrupts disabled
        mon_clr();
        cfg_wr(2'd2, TAG_BASE);
        cfg_wr(2'd3, 32'd0);
        cfg_wr(2'd0, 32'h104);
        wait_idle();
        chk("R4 count", 128'(n_wr), 128'd5);
        for (int i = 0; i < 5; i++) chk("R4 order", got[i], exp_d[i]);
        chk("R3 req count", 128'(n_req), 128'd7);
        chk("R3 first tag addr", 128'(req_a[0]), 128'(TAG_BASE));
        chk("R3 data addr load", 128'(req_a[1]), 128'h100);
        chk("R3 next tag addr", 128'(req_a[4]), 128'(TAG_BASE + 32'h10));
        chk("R9 spr select", 128'(req_s[5]), 128'd1);
        chk("R9 spr addr", 128'(req_a[5]), 128'h2040);
        chk("R5 flag ignored", 128'(n_irq), 128'd1);
        chk("R6 busy cleared", 128'(ctrl_o), 128'h004);

        // R3: end descriptor leaves the tag address in place
        mon_clr();
        cfg_wr(2'd0, 32'h104);
        wait_idle();
        chk("R3 tadr held", 128'(req_a[0]), 128'(TAG_BASE + 32'h10));
        chk("R3 restart count", 128'(n_wr), 128'd2);
        chk("R3 restart data", got[0], exp_d[3]);

        // R5: tag interrupt enable ends the chain at the flagged descriptor
        mon_clr();
        cfg_wr(2'd2, TAG_BASE);
        cfg_wr(2'd0, 32'h184);
        wait_idle();
        chk("R5 writes", 128'(n_wr), 128'd3);
        chk("R5 reqs", 128'(n_req), 128'd4);
        chk("R6 single irq", 128'(n_irq), 128'd1);
        chk("R6 ctrl", 128'(ctrl_o), 128'h084);
        mon_clr();
        cfg_wr(2'd0, 32'h184);
        wait_idle();
        chk("R5 tadr held", 128'(req_a[0]), 128'(TAG_BASE));
        chk("R5 rerun writes", 128'(n_wr), 128'd3);

        // R7: pause in the middle of a chain
        mon_clr();
        cfg_wr(2'd2, TAG_BASE);
        cfg_wr(2'd0, 32'h104);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (n_wr >= 2) break;
        end
        dreq = 1'b0;
        r0 = n_req;
        idle_cycles(20);
        chk("R7 no req while low", 128'(n_req), 128'(r0));
        chk("R7 no write while low", 128'(n_wr), 128'd2);
        chk("R7 still busy", 128'(ctrl_o[8]), 128'd1);
        dreq = 1'b1;
        wait_idle();
        chk("R7 resumed count", 128'(n_wr), 128'd5);
        chk("R7 resumed order", got[2], exp_d[2]);
        chk("R7 resumed tail", got[4], exp_d[4]);
        chk("R7 irq once", 128'(n_irq), 128'd1);

        // R8: start forces one step with the request line low
        dreq = 1'b0;
        mon_clr();
        cfg_wr(2'd2, TAG_BASE);
        cfg_wr(2'd0, 32'h104);
        idle_cycles(20);
        chk("R8 one step", 128'(n_req), 128'd1);
        chk("R8 tag first", 128'(req_a[0]), 128'(TAG_BASE));
        chk("R8 no data", 128'(n_wr), 128'd0);
        dreq = 1'b1;
        wait_idle();
        chk("R8 completes", 128'(n_wr), 128'd5);

        // R10: preloaded count moves data before any descriptor
        mon_clr();
        cfg_wr(2'd1, 32'h308);
        cfg_wr(2'd3, 32'd2);
        cfg_wr(2'd2, TAG_BASE + 32'h10);
        cfg_wr(2'd0, 32'h104);
        wait_idle();
        chk("R10 count", 128'(n_wr), 128'd4);
        chk("R10 first", got[0], pat(1'b0, 32'h300));
        chk("R10 second", got[1], pat(1'b0, 32'h310));
        chk("R10 tag after data", 128'(req_a[2]), 128'(TAG_BASE + 32'h10));
        chk("R10 chain data", got[2], exp_d[3]);

        // R9: address bit 31 routes to scratchpad
        mon_clr();
        cfg_wr(2'd1, 32'h8000_1238);
        cfg_wr(2'd3, 32'd1);
        cfg_wr(2'd2, TAG_BASE + 32'h10);
        cfg_wr(2'd0, 32'h104);
        wait_idle();
        chk("R9 bit31 spr", 128'(req_s[0]), 128'd1);
        chk("R9 bit31 addr", 128'(req_a[0]), 128'h1230);
        chk("R9 bit31 data", got[0], pat(1'b1, 32'h1230));
        chk("R9 total", 128'(n_wr), 128'd3);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule